// File: doc/BRIEF.md
# Page-Buffered Self-Timed Write Controller

This block sits between the serial bus front end of a byte-addressed nonvolatile store and its storage array. The front end announces a write command with its 12-bit start address, then passes each received data byte. The controller collects the bytes in a one-page holding buffer. The buffer index is the low address bits, so a run of bytes that passes the end of a page wraps back to the page start.

A stop pulse ends the command. If at least one byte arrived and write protect is low, the controller enters a programming cycle of fixed length, counted in system clocks. During that cycle it copies every loaded buffer slot into the array through its write port. It raises `busy_o` for the whole cycle, and the front end uses that signal to refuse acknowledges.

A protected stop and an empty stop both drop the buffer without starting a cycle. `PROG_CYCLES` must be at least `PAGE_BYTES` so that the copy fits inside the cycle.

Top module: `page_write_ctrl`

## Requirements
- R1: After reset, `busy_o` is low and `mem_we_o` stays low until a command is stopped.
- R2: A command carrying one byte writes exactly that byte to the header address once the cycle completes.
- R3: A command carrying N bytes (N up to 32) writes them to consecutive addresses from the header address. All the written addresses keep the header's upper address bits (bits 11:5).
- R4: The buffer slot is address bits 4:0, incremented modulo 32. Bytes past the page end wrap to offset 0 and overwrite bytes latched earlier in the same command, so the last byte for a slot wins.
- R5: Only slots loaded by the current command are written. Every other array location keeps its previous contents.
- R6: Neither the array nor `busy_o` changes while bytes are arriving. Programming starts only on the clock edge that samples `stop_i`.
- R7: `busy_o` rises on the edge that samples a qualifying stop and stays high for exactly `PROG_CYCLES` clocks. It is low again on the following clock, and new commands are accepted from then on.
- R8: If `wp_i` is high when the stop is sampled, the latched bytes are discarded, nothing is written and `busy_o` stays low. A later command commits only its own bytes.
- R9: A stop that follows a header with no data bytes starts no cycle and writes nothing.
- R10: While `busy_o` is high, `cmd_start_i`, `byte_valid_i` and `stop_i` are ignored. They cause no write and no further cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wp_i | input | 1 | Hardware write protect, sampled with stop |
| cmd_start_i | input | 1 | Pulse: new write command, header address valid |
| cmd_addr_i | input | ADDR_W | Start address of the command |
| byte_valid_i | input | 1 | Pulse: one data byte valid |
| byte_data_i | input | 8 | Data byte |
| stop_i | input | 1 | Pulse: command ended by stop |
| busy_o | output | 1 | Programming cycle in progress |
| mem_we_o | output | 1 | Array write enable |
| mem_addr_o | output | ADDR_W | Array write address |
| mem_wdata_o | output | 8 | Array write data |

## Verification
The hardest case to reach is a single command that laps the page buffer. The slot pointer has to pass offset 31 and come back to slots that were already loaded, so that a later byte must replace an earlier one before the commit. The bench starts a 34-byte command two slots before the page end. The last two bytes then land on the first two slots loaded, and the bench checks that only those final values reach the array. A second hard case is a protected stop followed by an unprotected command in the same page: any leftover loaded flags from the discarded command would show up as extra writes.

// File: rtl/page_write_ctrl.sv
module page_write_ctrl #(
  parameter int ADDR_W      = 12,
  parameter int PAGE_BYTES  = 32,
  parameter int PROG_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_i,
  input  logic              cmd_start_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_data_i,
  input  logic              stop_i,
  output logic              busy_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o
);
  localparam int IDX_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - IDX_W;
  localparam int CNT_W  = $clog2(PROG_CYCLES + 1);

  logic [7:0]            latch_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] loaded_q;
  logic [PAGE_W-1:0]     page_q;
  logic [IDX_W-1:0]      idx_q;
  logic [CNT_W-1:0]      cnt_q;
  logic [IDX_W:0]        scan_q;
  logic                  busy_q;

  wire               take_byte = !busy_q && !cmd_start_i && byte_valid_i;
  wire               take_stop = !busy_q && !cmd_start_i && !byte_valid_i && stop_i;
  wire [IDX_W-1:0]   scan_idx  = scan_q[IDX_W-1:0];
  wire               scanning  = busy_q && !scan_q[IDX_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loaded_q <= '0;
      page_q   <= '0;
      idx_q    <= '0;
      cnt_q    <= '0;
      scan_q   <= '0;
      busy_q   <= 1'b0;
    end else if (!busy_q) begin
      if (cmd_start_i) begin
        page_q   <= cmd_addr_i[ADDR_W-1:IDX_W];
        idx_q    <= cmd_addr_i[IDX_W-1:0];
        loaded_q <= '0;
      end else if (take_byte) begin
        loaded_q[idx_q] <= 1'b1;
        idx_q           <= idx_q + 1'b1;
      end else if (take_stop) begin
        if (loaded_q != '0 && !wp_i) begin
          busy_q <= 1'b1;
          cnt_q  <= CNT_W'(PROG_CYCLES - 1);
          scan_q <= '0;
        end else begin
          loaded_q <= '0;
        end
      end
    end else begin
      if (!scan_q[IDX_W]) scan_q <= scan_q + 1'b1;
      if (cnt_q == '0) begin
        busy_q   <= 1'b0;
        loaded_q <= '0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (take_byte) latch_q[idx_q] <= byte_data_i;
  end

  assign busy_o      = busy_q;
  assign mem_we_o    = scanning && loaded_q[scan_idx];
  assign mem_addr_o  = {page_q, scan_idx};
  assign mem_wdata_o = latch_q[scan_idx];
endmodule

// File: rtl/page_write_ctrl_chk.sv
module page_write_ctrl_chk #(
  parameter int PROG_CYCLES = 64
) (
  input logic clk,
  input logic rst_n,
  input logic wp_i,
  input logic stop_i,
  input logic busy_o,
  input logic mem_we_o
);
  localparam int RUN_W = $clog2(PROG_CYCLES + 2);
  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= '0;
    else if (busy_o) run_q <= run_q + 1'b1;
    else             run_q <= '0;
  end

  // R7
  busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> run_q < RUN_W'(PROG_CYCLES));

  // R7
  busy_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> run_q == RUN_W'(PROG_CYCLES));

  // R6
  start_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(stop_i));

  // R8
  wp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && wp_i && !busy_o) |=> !busy_o);

  // R1
  write_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> busy_o);
endmodule

bind page_write_ctrl page_write_ctrl_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .wp_i(wp_i), .stop_i(stop_i),
  .busy_o(busy_o), .mem_we_o(mem_we_o)
);

// File: tb/tb_page_write_ctrl.sv
`timescale 1ns/1ps
module tb_page_write_ctrl;
  localparam int ADDR_W = 12;
  localparam int PROG   = 48;
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wp = 1'b0, cmd_start = 1'b0, byte_valid = 1'b0, stop = 1'b0;
  logic [ADDR_W-1:0] cmd_addr = '0;
  logic [7:0] byte_data = '0;
  logic busy, mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0] mem_wdata;

  logic [7:0] arr [DEPTH];
  logic [7:0] exp_mem [DEPTH];
  int wr_count = 0;
  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  page_write_ctrl #(.ADDR_W(ADDR_W), .PAGE_BYTES(32), .PROG_CYCLES(PROG)) dut (
    .clk(clk), .rst_n(rst_n), .wp_i(wp), .cmd_start_i(cmd_start), .cmd_addr_i(cmd_addr),
    .byte_valid_i(byte_valid), .byte_data_i(byte_data), .stop_i(stop),
    .busy_o(busy), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata));

  always @(posedge clk) if (mem_we) begin
    arr[mem_addr] <= mem_wdata;
    wr_count <= wr_count + 1;
  end

  task automatic check(input string req, input int act, input int expv);
    tests++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic check_mem(input string req);
    int bad = -1;
    for (int a = 0; a < DEPTH; a++) if (bad < 0 && arr[a] !== exp_mem[a]) bad = a;
    tests++;
    if (bad >= 0) begin
      fails++;
      $display("FAIL %s: addr %0h actual %0h expected %0h", req, bad, arr[bad], exp_mem[bad]);
    end
  endtask

  task automatic send_cmd(input logic [ADDR_W-1:0] a, input int n, input logic [7:0] seed);
    cmd_start = 1'b1; cmd_addr = a;
    @(negedge clk); cmd_start = 1'b0;
    for (int i = 0; i < n; i++) begin
      byte_valid = 1'b1; byte_data = seed + 8'(i);
      @(negedge clk);
    end
    byte_valid = 1'b0;
  endtask

  task automatic send_stop();
    stop = 1'b1;
    @(negedge clk); stop = 1'b0;
  endtask

  task automatic model(input logic [ADDR_W-1:0] a, input int n, input logic [7:0] seed);
    for (int i = 0; i < n; i++)
      exp_mem[{a[ADDR_W-1:5], 5'(a[4:0] + 5'(i))}] = seed + 8'(i);
  endtask

  task automatic run_cycle(output int len);
    len = 0;
    while (busy && len < 10 * PROG) begin
      len++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    check("R1 busy after reset", int'(busy), 0);
    repeat (5) @(negedge clk);
    check("R1 no writes after reset", wr_count, 0);
  endtask

  task automatic t_single();
    int len;
    send_cmd(12'h123, 1, 8'hA5);
    send_stop();
    check("R7 busy rises after stop", int'(busy), 1);
    run_cycle(len);
    check("R7 busy length", len, PROG);
    model(12'h123, 1, 8'hA5);
    check_mem("R2 single byte");
    check("R2 one write", wr_count, 1);
  endtask

  task automatic t_page();
    int len, w0 = wr_count;
    send_cmd(12'h7E0, 32, 8'h10);
    send_stop();
    run_cycle(len);
    model(12'h7E0, 32, 8'h10);
    check_mem("R3 full page");
    check("R3 write count", wr_count - w0, 32);
  endtask

  task automatic t_wrap();
    int len, w0 = wr_count;
    send_cmd(12'h41C, 6, 8'h60);
    send_stop();
    run_cycle(len);
    model(12'h41C, 6, 8'h60);
    check_mem("R4 wrap to page start");
    w0 = wr_count;
    send_cmd(12'h21E, 34, 8'h80);
    send_stop();
    run_cycle(len);
    model(12'h21E, 34, 8'h80);
    check_mem("R4 overwrite on lap");
    check("R4 lap write count", wr_count - w0, 32);
  endtask

  task automatic t_partial();
    int len, w0 = wr_count;
    send_cmd(12'h305, 3, 8'hC0);
    send_stop();
    run_cycle(len);
    model(12'h305, 3, 8'hC0);
    check_mem("R5 unloaded slots kept");
    check("R5 write count", wr_count - w0, 3);
  endtask

  task automatic t_nostop();
    int len, w0 = wr_count;
    send_cmd(12'h550, 4, 8'h30);
    repeat (10) @(negedge clk);
    check("R6 busy before stop", int'(busy), 0);
    check("R6 no write before stop", wr_count - w0, 0);
    send_stop();
    check("R6 busy at stop", int'(busy), 1);
    run_cycle(len);
    model(12'h550, 4, 8'h30);
    check_mem("R6 commit after stop");
  endtask

  task automatic t_wp();
    int len, w0 = wr_count;
    send_cmd(12'h600, 8, 8'hE0);
    wp = 1'b1;
    send_stop();
    wp = 1'b0;
    check("R8 busy after protected stop", int'(busy), 0);
    repeat (PROG + 5) @(negedge clk);
    check("R8 no write", wr_count - w0, 0);
    check_mem("R8 array unchanged");
    send_cmd(12'h604, 1, 8'h44);
    send_stop();
    run_cycle(len);
    model(12'h604, 1, 8'h44);
    check_mem("R8 discarded bytes not committed");
    check("R8 later command write count", wr_count - w0, 1);
  endtask

  task automatic t_empty();
    int w0 = wr_count;
    send_cmd(12'h700, 0, 8'h00);
    send_stop();
    check("R9 busy after empty stop", int'(busy), 0);
    repeat (PROG) @(negedge clk);
    check("R9 no write", wr_count - w0, 0);
  endtask

  task automatic t_busy_ignore();
    int len, w0;
    send_cmd(12'h0A0, 2, 8'h11);
    send_stop();
    w0 = wr_count;
    send_cmd(12'h0B0, 4, 8'h99);
    send_stop();
    run_cycle(len);
    check("R10 cycle not extended", len, PROG - 6);
    model(12'h0A0, 2, 8'h11);
    repeat (PROG + 5) @(negedge clk);
    check("R10 no second cycle", int'(busy), 0);
    check("R10 ignored bytes not written", wr_count - w0, 2);
    check_mem("R10 array after busy");
  endtask

  initial begin
    for (int a = 0; a < DEPTH; a++) begin
      arr[a] = 8'(a ^ 8'h5A);
      exp_mem[a] = 8'(a ^ 8'h5A);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_page();
    t_wrap();
    t_partial();
    t_nostop();
    t_wp();
    t_empty();
    t_busy_ignore();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule